// File: doc/BRIEF.md
# Edge-Detect Interrupt Unit

This block watches twenty-four digital input lines, grouped as three ports of eight, and records qualifying signal edges as interrupt events. Software picks the direction of interest for each line through a polarity register and lets the line take part through an enable register. Both registers are per port and write-only. A line that is enabled and sees an edge in its selected direction sets a sticky bit in its port's event (ID) register.

Software reads the event bits, and a summary pending byte names the ports that hold at least one event. An active-high interrupt request is raised while any event is held. A handler reads the pending byte, reads the event register of each flagged port, and then writes that register to clear the bits it has serviced.

The line inputs are asynchronous to the clock. Each one passes through a two-stage synchronizer before edge detection. All register accesses are single-cycle write strobes with a shared data byte. No back-pressure exists on any pin.

Top module: `edge_irq_unit`

## Requirements
- R1: Line n maps to event bit n of `id_q`, which is bit n mod 8 of port n/8. Port p's polarity, enable and clear strobes are bit p of `pol_we`, `en_we` and `id_we`.
- R2: A polarity bit of 1 makes its line detect rising edges only. A polarity bit of 0 makes it detect falling edges only. An edge in the other direction leaves the event bit at 0.
- R3: A line whose enable bit is 0 never sets its event bit, whatever its pin does.
- R4: An event bit, once set, stays set when the pin returns to its former level. It stays set until it is cleared by a write.
- R5: A strobe on `id_we[p]` clears each event bit of port p whose `wr_data` bit is 0 and keeps each bit whose `wr_data` bit is 1. Writing 0 therefore clears the whole port.
- R6: `pend_q[p]` is 1 exactly when port p holds at least one event bit, for p in 0..2. `pend_q[7:3]` always reads 0.
- R7: `irq` is high exactly when at least one event bit in any port is set.
- R8: After reset, all polarity, enable and event bits are 0. No line is enabled, the default polarity is falling edge, and `irq` and `pend_q` are 0.
- R9: If a qualifying edge is detected in the same cycle as a clearing write to its port, that line's event bit stays 1.
- R10: A pin change shows in `id_q` after the third rising clock edge that follows it, and not after the second.
- R11: A polarity, enable or clear write to one port leaves the registers of the other ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 24 | Asynchronous line levels |
| wr_data | input | 8 | Data byte for any register write |
| pol_we | input | 3 | Per-port polarity write strobe |
| en_we | input | 3 | Per-port enable write strobe |
| id_we | input | 3 | Per-port event clear strobe (clears bits where data is 0) |
| id_q | output | 24 | Event bits of all three ports |
| pend_q | output | 8 | Summary: bit p set if port p holds an event |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that every input holds a known level from reset onward. They also assume the pins sit at a steady level through reset, so the synchronizer's history agrees with the pins when reset is released. The bench holds all pins low during reset and changes pins and strobes only on falling clock edges or shortly after rising edges. It raises a single strobe per write, so each register update is attributable to one access.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int PORT_W_DEF = 8;
  localparam int NPORT_DEF  = 3;
  localparam int PEND_W_DEF = 8;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign rise_o = cur_q & ~prev_q;
  assign fall_o = ~cur_q & prev_q;
  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/edge_port.sv
module edge_port #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] rise_i,
  input  logic [PW-1:0] fall_i,
  input  logic [PW-1:0] wr_data,
  input  logic          pol_we,
  input  logic          en_we,
  input  logic          id_we,
  output logic [PW-1:0] id_o,
  output logic [PW-1:0] pol_o,
  output logic [PW-1:0] en_o
);
  logic [PW-1:0] pol_q, en_q, id_q, evt, keep;

  assign evt  = en_q & ((pol_q & rise_i) | (~pol_q & fall_i));
  assign keep = id_we ? (id_q & wr_data) : id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      en_q  <= '0;
      id_q  <= '0;
    end else begin
      if (pol_we) pol_q <= wr_data;
      if (en_we)  en_q  <= wr_data;
      id_q <= keep | evt;
    end
  end

  assign id_o  = id_q;
  assign pol_o = pol_q;
  assign en_o  = en_q;
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import edge_irq_pkg::*;
#(
  parameter int PW     = PORT_W_DEF,
  parameter int NPORT  = NPORT_DEF,
  parameter int PEND_W = PEND_W_DEF,
  localparam int NL    = PW * NPORT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NL-1:0]     pin_i,
  input  logic [PW-1:0]     wr_data,
  input  logic [NPORT-1:0]  pol_we,
  input  logic [NPORT-1:0]  en_we,
  input  logic [NPORT-1:0]  id_we,
  output logic [NL-1:0]     id_q,
  output logic [PEND_W-1:0] pend_q,
  output logic              irq
);
  logic [NL-1:0] rise, fall, cur_s, prev_s, pol_all, en_all;

  edge_sync #(.N(NL)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .rise_o(rise), .fall_o(fall), .cur_o(cur_s), .prev_o(prev_s)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    edge_port #(.PW(PW)) u_port (
      .clk(clk), .rst_n(rst_n),
      .rise_i(rise[p*PW +: PW]), .fall_i(fall[p*PW +: PW]),
      .wr_data(wr_data),
      .pol_we(pol_we[p]), .en_we(en_we[p]), .id_we(id_we[p]),
      .id_o(id_q[p*PW +: PW]),
      .pol_o(pol_all[p*PW +: PW]),
      .en_o(en_all[p*PW +: PW])
    );
  end

  always_comb begin
    pend_q = '0;
    for (int p = 0; p < NPORT; p++) pend_q[p] = |id_q[p*PW +: PW];
  end

  assign irq = |id_q;
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
  parameter int PW     = 8,
  parameter int NPORT  = 3,
  parameter int PEND_W = 8,
  localparam int NL    = PW * NPORT
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NL-1:0]     id_q,
  input logic [PEND_W-1:0] pend_q,
  input logic              irq,
  input logic [NPORT-1:0]  id_we,
  input logic [NL-1:0]     en_all,
  input logic [NL-1:0]     pol_all,
  input logic [NL-1:0]     cur_s,
  input logic [NL-1:0]     prev_s
);
  // R3: a newly set event bit needs its enable set the cycle before
  a_r3_no_event_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    ((id_q & ~$past(id_q)) & ~$past(en_all)) == '0);

  // R2: a newly set event bit needs an edge in the selected direction
  a_r2_polarity_match: assert property (@(posedge clk) disable iff (!rst_n)
    ((id_q & ~$past(id_q)) &
     ~$past((pol_all & cur_s & ~prev_s) | (~pol_all & ~cur_s & prev_s))) == '0);

  // R7: request follows the pending summary
  a_r7_irq_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|pend_q));

  // R6: upper summary bits stay zero
  a_r6_upper_pending_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q >> NPORT) == '0);

  // R5: an event bit only falls after a clear strobe to its port
  for (genvar p = 0; p < NPORT; p++) begin : g_clr
    a_r5_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(id_q[p*PW +: PW]) & ~id_q[p*PW +: PW]) != '0) |-> $past(id_we[p]));
  end
endmodule

bind edge_irq_unit edge_irq_chk #(.PW(PW), .NPORT(NPORT), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_q(id_q), .pend_q(pend_q), .irq(irq),
  .id_we(id_we), .en_all(en_all), .pol_all(pol_all),
  .cur_s(cur_s), .prev_s(prev_s)
);

// File: tb/sim_edge_irq_unit.sv
`timescale 1ns/1ps
module sim_edge_irq_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] pin_i = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  pol_we = '0, en_we = '0, id_we = '0;
  logic [23:0] id_q;
  logic [7:0]  pend_q;
  logic        irq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  edge_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_data(wr_data),
    .pol_we(pol_we), .en_we(en_we), .id_we(id_we),
    .id_q(id_q), .pend_q(pend_q), .irq(irq)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 polarity, 1 enable, 2 clear
  task automatic wr(input int kind, input int port, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    case (kind)
      0: pol_we[port] = 1'b1;
      1: en_we[port]  = 1'b1;
      default: id_we[port] = 1'b1;
    endcase
    @(posedge clk); #2;
    pol_we = '0; en_we = '0; id_we = '0;
  endtask

  task automatic drive(input logic [23:0] v);
    @(negedge clk); pin_i = v;
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    check(id_q == 0, "R8 id", id_q, 0);
    check(pend_q == 0 && irq == 0, "R8 pend/irq", {pend_q, 7'd0, irq}, 0);
    drive(24'hFFFFFF); drive(24'h0);
    check(id_q == 0, "R3 disabled after reset", id_q, 0);
  endtask

  task automatic t_falling;
    wr(1, 0, 8'hFF); wr(0, 0, 8'h00);
    drive(24'h000001);
    check(id_q == 0, "R2 rising ignored on falling line", id_q, 0);
    @(negedge clk); pin_i = 24'h0;
    repeat (2) @(posedge clk); #2;
    check(id_q == 0, "R10 not after two edges", id_q, 0);
    @(posedge clk); #2;
    check(id_q == 24'h1, "R10/R2 falling latched", id_q, 24'h1);
    drive(24'h000001);
    check(id_q == 24'h1, "R4 sticky", id_q, 24'h1);
    check(pend_q == 8'h01, "R6 pend port0", pend_q, 8'h01);
    check(irq == 1'b1, "R7 irq high", irq, 1);
  endtask

  task automatic t_rising;
    wr(0, 1, 8'hFF); wr(1, 1, 8'h0F);
    drive(24'h00FF01);
    check(id_q == 24'h000F01, "R3/R2 rising port1 enabled nibble", id_q, 24'h000F01);
    check(pend_q == 8'h03, "R6 pend ports0,1", pend_q, 8'h03);
  endtask

  task automatic t_clear;
    wr(2, 0, 8'h00);
    check(id_q == 24'h000F00, "R5/R11 port0 cleared only", id_q, 24'h000F00);
    wr(2, 1, 8'h0C);
    check(id_q == 24'h000C00, "R5 partial clear", id_q, 24'h000C00);
    check(pend_q == 8'h02, "R6 pend port1", pend_q, 8'h02);
  endtask

  task automatic t_port2;
    wr(0, 2, 8'h80); wr(1, 2, 8'h80);
    drive(24'h80FF01);
    check(id_q == 24'h800C00, "R1 line23 maps to bit23", id_q, 24'h800C00);
    check(pend_q == 8'h06, "R6 pend ports1,2 upper zero", pend_q, 8'h06);
  endtask

  task automatic t_collide;
    wr(2, 2, 8'h00);
    check(id_q == 24'h000C00, "R5 port2 cleared", id_q, 24'h000C00);
    drive(24'h00FF01);
    check(id_q == 24'h000C00, "R2 falling ignored on rising line", id_q, 24'h000C00);
    @(negedge clk); pin_i = 24'h80FF01;
    repeat (2) @(posedge clk);
    @(negedge clk); wr_data = 8'h00; id_we[2] = 1'b1;
    @(posedge clk); #2; id_we = '0;
    check(id_q == 24'h800C00, "R9 edge beats clear", id_q, 24'h800C00);
  endtask

  task automatic t_final;
    wr(2, 1, 8'h00); wr(2, 2, 8'h00);
    check(id_q == 0, "R5 all clear", id_q, 0);
    check(irq == 1'b0 && pend_q == 0, "R7 irq low", {pend_q, 7'd0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;
    t_reset(); t_falling(); t_rising(); t_clear(); t_port2(); t_collide(); t_final();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule